// File: doc/BRIEF.md
# H-Bridge Mode Sequencer with Synchronous Rectification

This block turns a power-enable input and two direction inputs into the four gate enables of a full H-bridge: a high-side and a low-side switch on leg A, and the same on leg B. It decodes five operating conditions: standby, output-off, forward, reverse and brake. All inputs are asynchronous to the block clock, so each one passes through a flop synchronizer before it is used.

A driven mode does not drop straight to all-off when it ends. The block first closes the second low-side switch, so both low sides conduct and the load current decays quickly. That synchronous-rectification phase ends when a digital zero-current flag is seen, which keeps the current from reversing. It also ends when a cycle timeout expires, or when a new drive request arrives. Every change of the switch pattern passes through a dead interval. During that interval only the switches that are on in both the old and the new pattern stay on. The direction inputs may be toggled as PWM, and the block follows each edge.

Top module: `hbridge_mode_ctrl`

## Requirements
- R1: While pwr_en is low, the block is in standby: neither high-side switch is ever turned on, whatever dir_a and dir_b are, and once settled all four gates are off.
- R2: With pwr_en high and dir_a=0, dir_b=0, the settled gate pattern {hs_a,ls_a,hs_b,ls_b} is 0000 (output off).
- R3: With pwr_en high, dir_a=1 and dir_b=0 (forward), the settled pattern is 1001, and hs_a only ever rises in response to a forward request.
- R4: With pwr_en high, dir_a=0 and dir_b=1 (reverse), the settled pattern is 0110, and hs_b only ever rises in response to a reverse request.
- R5: With pwr_en high, dir_a=1 and dir_b=1 (brake), the settled pattern is 0101.
- R6: An input change first shows at the gates after the third rising clock edge that follows it. The path is two synchronizer flops plus the gate register, at the default SYNC_STAGES=2.
- R7: Every change of the gate pattern first holds, for exactly DEAD_CYC cycles, the pattern of the switches that are on in both the old and the new pattern. A switch never turns on unless the opposite switch on its leg has been off for at least DEAD_CYC cycles.
- R8: When the request leaves forward or reverse for output-off or standby, the dead interval is followed by the rectification pattern 0101 (both low sides on). That pattern holds while the zero-current flag stays low.
- R9: zero_cur passes through the same synchronizer. The third rising edge after it rises ends rectification: the gates go to 0000, and after the dead interval they stay there.
- R10: If zero_cur never rises, rectification lasts exactly SR_TIMEOUT cycles, and then the gates go to 0000.
- R11: A drive request that arrives during rectification ends it at once. The block moves through the dead interval straight to the new drive pattern. When the request and the zero-current flag arrive in the same cycle, the drive request wins.
- R12: The two switches of one leg are never on together. leg_fault flags that combination and stays low.
- R13: During and right after reset all gates are off and leg_fault is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_en | input | 1 | Power enable; low selects standby |
| dir_a | input | 1 | Direction input A (forward when alone) |
| dir_b | input | 1 | Direction input B (reverse when alone) |
| zero_cur | input | 1 | Load current has reached zero |
| hs_a | output | 1 | Leg A high-side gate enable |
| ls_a | output | 1 | Leg A low-side gate enable |
| hs_b | output | 1 | Leg B high-side gate enable |
| ls_b | output | 1 | Leg B low-side gate enable |
| leg_fault | output | 1 | Both switches of one leg on |

## Verification
Two events can land in the same cycle during rectification: the end of the phase on the zero-current flag, and a fresh forward request that also ends it. The bench holds the bridge in rectification, then raises zero_cur and requests forward on the same clock. It judges the result by the dead pattern that appears three edges later. The expected pattern is 0001, the part of the rectification pattern that forward keeps, followed by 1001. The pattern 0000 would show that the flag had been given priority. Separate per-cycle monitors check the leg exclusion and the minimum off time before any switch turns on, including during a burst of input toggles faster than the dead interval.

// File: rtl/hbr_pkg.sv
package hbr_pkg;

   // Mode the sequencer is heading to or has applied.
   typedef enum logic [2:0] {
      MD_OFF = 3'd0,
      MD_FWD = 3'd1,
      MD_REV = 3'd2,
      MD_BRK = 3'd3,
      MD_SR  = 3'd4
   } hb_mode_e;

   // Gate vector bit order: {hs_a, ls_a, hs_b, ls_b}
   localparam int GATE_W = 4;
   localparam logic [GATE_W-1:0] PAT_OFF = 4'b0000;
   localparam logic [GATE_W-1:0] PAT_FWD = 4'b1001;
   localparam logic [GATE_W-1:0] PAT_REV = 4'b0110;
   localparam logic [GATE_W-1:0] PAT_LOW = 4'b0101;

   function automatic logic [GATE_W-1:0] mode_gates(input hb_mode_e m);
      case (m)
         MD_FWD:         return PAT_FWD;
         MD_REV:         return PAT_REV;
         MD_BRK, MD_SR:  return PAT_LOW;
         default:        return PAT_OFF;
      endcase
   endfunction

   function automatic logic is_drive(input hb_mode_e m);
      return (m == MD_FWD) || (m == MD_REV);
   endfunction

endpackage

// File: rtl/hbr_sync.sv
module hbr_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("hbr_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("hbr_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= '0;
            else        chain[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= '0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/hbr_decode.sv
module hbr_decode
   import hbr_pkg::*;
(
   input  logic     pwr_en,
   input  logic     dir_a,
   input  logic     dir_b,
   output hb_mode_e target
);
   always_comb begin
      if (!pwr_en) begin
         target = MD_OFF;
      end else begin
         case ({dir_a, dir_b})
            2'b10:   target = MD_FWD;
            2'b01:   target = MD_REV;
            2'b11:   target = MD_BRK;
            default: target = MD_OFF;
         endcase
      end
   end
endmodule

// File: rtl/hbr_seq.sv
module hbr_seq
   import hbr_pkg::*;
#(
   parameter int DEAD_CYC   = 13,
   parameter int SR_TIMEOUT = 500,
   parameter bit SR_EN      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  hb_mode_e          target,
   input  logic              zc,
   output logic [GATE_W-1:0] gates
);
   localparam int CMAX = (DEAD_CYC > SR_TIMEOUT) ? DEAD_CYC : SR_TIMEOUT;
   localparam int CW   = $clog2(CMAX + 1);
   localparam logic [CW-1:0] DEAD_LOAD = CW'(DEAD_CYC - 1);
   localparam logic [CW-1:0] SR_LOAD   = CW'(SR_TIMEOUT - 1);

   if (DEAD_CYC < 1) begin : g_bad_dead
      $error("hbr_seq: DEAD_CYC must be at least 1");
   end
   if (SR_TIMEOUT < 1) begin : g_bad_tmo
      $error("hbr_seq: SR_TIMEOUT must be at least 1");
   end

   typedef enum logic [1:0] {ST_RUN, ST_DEAD, ST_SR} st_e;

   st_e               st_q;
   logic [CW-1:0]     cnt_q;
   logic [GATE_W-1:0] gates_q;
   hb_mode_e          applied_q;
   hb_mode_e          goal_q;
   logic              sr_allowed;
   hb_mode_e          plan;

   // Variant choice: with rectification disabled the bridge goes straight to off.
   if (SR_EN) begin : g_sr_on
      assign sr_allowed = 1'b1;
   end else begin : g_sr_off
      assign sr_allowed = 1'b0;
   end

   // Mode to head for, given what is applied now and what is requested.
   always_comb begin
      if (sr_allowed && (target == MD_OFF) && is_drive(applied_q)) plan = MD_SR;
      else                                                         plan = target;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_RUN;
         cnt_q     <= '0;
         gates_q   <= PAT_OFF;
         applied_q <= MD_OFF;
         goal_q    <= MD_OFF;
      end else begin
         case (st_q)
            ST_RUN: begin
               if (target != applied_q) begin
                  goal_q  <= plan;
                  gates_q <= gates_q & mode_gates(plan);
                  cnt_q   <= DEAD_LOAD;
                  st_q    <= ST_DEAD;
               end
            end
            ST_DEAD: begin
               if (cnt_q != '0) begin
                  cnt_q <= cnt_q - 1'b1;
               end else if (plan != goal_q) begin
                  // Request moved while waiting: restart from the safe subset.
                  goal_q  <= plan;
                  gates_q <= gates_q & mode_gates(plan);
                  cnt_q   <= DEAD_LOAD;
               end else begin
                  gates_q   <= mode_gates(goal_q);
                  applied_q <= goal_q;
                  if (goal_q == MD_SR) begin
                     cnt_q <= SR_LOAD;
                     st_q  <= ST_SR;
                  end else begin
                     st_q  <= ST_RUN;
                  end
               end
            end
            ST_SR: begin
               if ((target != MD_OFF) || zc || (cnt_q == '0)) begin
                  // A new drive request takes priority over the flag.
                  goal_q  <= target;
                  gates_q <= gates_q & mode_gates(target);
                  cnt_q   <= DEAD_LOAD;
                  st_q    <= ST_DEAD;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: st_q <= ST_RUN;
         endcase
      end
   end

   assign gates = gates_q;
endmodule

// File: rtl/hbridge_mode_ctrl.sv
module hbridge_mode_ctrl
   import hbr_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int DEAD_CYC    = 13,
   parameter int SR_TIMEOUT  = 500,
   parameter bit SR_EN       = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_en,
   input  logic dir_a,
   input  logic dir_b,
   input  logic zero_cur,
   output logic hs_a,
   output logic ls_a,
   output logic hs_b,
   output logic ls_b,
   output logic leg_fault
);
   localparam int IN_W = 4;

   logic [IN_W-1:0]   raw_in;
   logic [IN_W-1:0]   syn_in;
   hb_mode_e          target;
   logic [GATE_W-1:0] gates;

   assign raw_in = {pwr_en, dir_a, dir_b, zero_cur};

   hbr_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (syn_in)
   );

   hbr_decode u_dec (
      .pwr_en (syn_in[3]),
      .dir_a  (syn_in[2]),
      .dir_b  (syn_in[1]),
      .target (target)
   );

   hbr_seq #(.DEAD_CYC(DEAD_CYC), .SR_TIMEOUT(SR_TIMEOUT), .SR_EN(SR_EN)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .target (target),
      .zc     (syn_in[0]),
      .gates  (gates)
   );

   assign {hs_a, ls_a, hs_b, ls_b} = gates;
   assign leg_fault = (hs_a & ls_a) | (hs_b & ls_b);
endmodule

// File: rtl/hbr_checker.sv
module hbr_checker #(
   parameter int LAT = 3
) (
   input logic clk,
   input logic rst_n,
   input logic pwr_en,
   input logic dir_a,
   input logic dir_b,
   input logic hs_a,
   input logic ls_a,
   input logic hs_b,
   input logic ls_b,
   input logic leg_fault
);
   localparam int FW = $clog2(LAT + 1);

   // Request history: {standby, forward, reverse} as sampled at the pins.
   logic [2:0]    req_pipe [LAT];
   logic [FW-1:0] fill;
   logic          armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < LAT; i++) req_pipe[i] <= '0;
         fill <= '0;
      end else begin
         req_pipe[0] <= {!pwr_en, pwr_en & dir_a & !dir_b, pwr_en & !dir_a & dir_b};
         for (int i = 1; i < LAT; i++) req_pipe[i] <= req_pipe[i-1];
         if (fill != FW'(LAT)) fill <= fill + 1'b1;
      end
   end

   assign armed = (fill == FW'(LAT));

   assert_no_fault_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !leg_fault && !(hs_a && ls_a) && !(hs_b && ls_b));

   assert_gap_ls_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fill != '0) && $rose(ls_a) |-> !$past(hs_a));
   assert_gap_hs_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fill != '0) && $rose(hs_a) |-> !$past(ls_a));
   assert_gap_ls_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fill != '0) && $rose(ls_b) |-> !$past(hs_b));
   assert_gap_hs_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fill != '0) && $rose(hs_b) |-> !$past(ls_b));

   assert_standby_no_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
      armed && req_pipe[LAT-1][2] |-> !hs_a && !hs_b);

   assert_hs_a_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $rose(hs_a) |-> req_pipe[LAT-1][1]);

   assert_hs_b_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $rose(hs_b) |-> req_pipe[LAT-1][0]);
endmodule

bind hbridge_mode_ctrl hbr_checker #(.LAT(SYNC_STAGES + 1)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pwr_en    (pwr_en),
   .dir_a     (dir_a),
   .dir_b     (dir_b),
   .hs_a      (hs_a),
   .ls_a      (ls_a),
   .hs_b      (hs_b),
   .ls_b      (ls_b),
   .leg_fault (leg_fault)
);

// File: tb/tb_hbridge_mode_ctrl.sv
module tb_hbridge_mode_ctrl;
   localparam int DEAD   = 13;
   localparam int TMO    = 500;
   localparam int SETTLE = 40;
   localparam int NVEC   = 11;

   // Each entry: {pwr_en, dir_a, dir_b, expected {hs_a,ls_a,hs_b,ls_b}}
   localparam logic [6:0] VEC [NVEC] = '{
      {3'b110, 4'b1001}, {3'b111, 4'b0101}, {3'b101, 4'b0110},
      {3'b100, 4'b0000}, {3'b010, 4'b0000}, {3'b011, 4'b0000},
      {3'b001, 4'b0000}, {3'b101, 4'b0110}, {3'b110, 4'b1001},
      {3'b111, 4'b0101}, {3'b000, 4'b0000}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_en = 1'b0, dir_a = 1'b0, dir_b = 1'b0, zero_cur = 1'b0;
   logic hs_a, ls_a, hs_b, ls_b, leg_fault;

   int checks = 0;
   int errors = 0;
   int mon_fault = 0;
   int mon_gap = 0;
   int cyc = 0;

   always #10 clk = ~clk;

   hbridge_mode_ctrl #(.DEAD_CYC(DEAD), .SR_TIMEOUT(TMO)) dut (
      .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .dir_a(dir_a), .dir_b(dir_b),
      .zero_cur(zero_cur), .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b),
      .leg_fault(leg_fault)
   );

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         checks++;
         errors++;
         $display("FAIL watchdog (all requirements): actual=hung expected=finished");
         finish_run();
      end
   end

   // Per-cycle monitors for leg exclusion (R12) and minimum off time (R7).
   int off_hsa = 1000, off_lsa = 1000, off_hsb = 1000, off_lsb = 1000;
   logic [3:0] prev = 4'b0000;
   always @(negedge clk) begin
      if (rst_n) begin
         if ((hs_a && ls_a) || (hs_b && ls_b) || leg_fault) mon_fault++;
         if (ls_a && !prev[2] && off_hsa < DEAD) mon_gap++;
         if (hs_a && !prev[3] && off_lsa < DEAD) mon_gap++;
         if (ls_b && !prev[0] && off_hsb < DEAD) mon_gap++;
         if (hs_b && !prev[1] && off_lsb < DEAD) mon_gap++;
         off_hsa = hs_a ? 0 : ((off_hsa < 1000) ? off_hsa + 1 : off_hsa);
         off_lsa = ls_a ? 0 : ((off_lsa < 1000) ? off_lsa + 1 : off_lsa);
         off_hsb = hs_b ? 0 : ((off_hsb < 1000) ? off_hsb + 1 : off_hsb);
         off_lsb = ls_b ? 0 : ((off_lsb < 1000) ? off_lsb + 1 : off_lsb);
         prev = {hs_a, ls_a, hs_b, ls_b};
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drive(input logic p, input logic a, input logic b);
      pwr_en = p; dir_a = a; dir_b = b;
   endtask

   task automatic chk(input string req, input logic [3:0] exp);
      logic [3:0] act;
      act = {hs_a, ls_a, hs_b, ls_b};
      checks++;
      if (act !== exp || leg_fault !== 1'b0) begin
         errors++;
         $display("FAIL %s: gates actual=%b expected=%b (leg_fault=%b)", req, act, exp, leg_fault);
      end
   endtask

   function automatic string vec_req(input logic [2:0] in);
      if (!in[2])          return "R1 standby";
      case (in[1:0])
         2'b10:   return "R3 forward";
         2'b01:   return "R4 reverse";
         2'b11:   return "R5 brake";
         default: return "R2 output off";
      endcase
   endfunction

   initial begin
      // R13: reset state
      step(3);
      chk("R13 during reset", 4'b0000);
      rst_n = 1'b1;
      step(2);
      chk("R13 after reset", 4'b0000);

      // Truth table walk, zero-current flag held high
      zero_cur = 1'b1;
      for (int i = 0; i < NVEC; i++) begin
         drive(VEC[i][6], VEC[i][5], VEC[i][4]);
         step(SETTLE);
         chk(vec_req(VEC[i][6:4]), VEC[i][3:0]);
      end

      // R6/R7: forward -> brake, exact latency and dead pattern 0001
      drive(1, 1, 0); step(SETTLE); chk("R3 forward setup", 4'b1001);
      drive(1, 1, 1);
      step(2); chk("R6 no change after second edge", 4'b1001);
      step(1); chk("R6 first change on third edge, R7 dead subset", 4'b0001);
      step(DEAD - 1); chk("R7 dead pattern held for DEAD_CYC", 4'b0001);
      step(1); chk("R7 brake applied after dead interval", 4'b0101);

      // R8/R9: forward -> off with rectification ended by zero current
      drive(1, 1, 0); step(SETTLE); chk("R3 forward setup", 4'b1001);
      zero_cur = 1'b0;
      drive(1, 0, 0);
      step(3); chk("R7 dead before rectification", 4'b0001);
      step(DEAD); chk("R8 rectification both low sides", 4'b0101);
      step(50); chk("R8 rectification held while flag low", 4'b0101);
      zero_cur = 1'b1;
      step(2); chk("R9 flag still in synchronizer", 4'b0101);
      step(1); chk("R9 rectification ends on zero current", 4'b0000);
      step(DEAD + 2); chk("R9 settled off", 4'b0000);

      // R8/R10: reverse -> standby, flag never arrives
      drive(1, 0, 1); step(SETTLE); chk("R4 reverse setup", 4'b0110);
      zero_cur = 1'b0;
      drive(0, 0, 1);
      step(3 + DEAD); chk("R8 rectification on entering standby", 4'b0101);
      step(TMO - 1); chk("R10 rectification lasts SR_TIMEOUT", 4'b0101);
      step(1); chk("R10 timeout releases to off", 4'b0000);
      step(DEAD + 2); chk("R10 settled off", 4'b0000);

      // R11: drive request during rectification
      drive(1, 1, 0); step(SETTLE); chk("R3 forward setup", 4'b1001);
      drive(1, 0, 0);
      step(3 + DEAD); chk("R8 rectification before interrupt", 4'b0101);
      step(5);
      drive(1, 1, 0);
      step(2); chk("R11 still rectifying before request lands", 4'b0101);
      step(1); chk("R11 dead subset toward forward", 4'b0001);
      step(DEAD); chk("R11 forward resumes", 4'b1001);

      // R11: request and zero-current flag in the same cycle
      drive(1, 0, 0);
      step(3 + DEAD); chk("R8 rectification before collision", 4'b0101);
      zero_cur = 1'b1;
      drive(1, 1, 0);
      step(3); chk("R11 drive request wins over zero current", 4'b0001);
      step(DEAD); chk("R11 forward after collision", 4'b1001);

      // PWM burst faster than the dead interval, then settle (R3, R7, R12)
      for (int k = 0; k < 12; k++) begin
         drive(1, k[0] ? 1'b0 : 1'b1, 1'b0);
         step(7);
      end
      drive(1, 1, 0);
      step(SETTLE); chk("R3 forward after PWM burst", 4'b1001);

      // R1: standby from brake, then monitors
      drive(0, 1, 1); step(SETTLE); chk("R1 standby from brake", 4'b0000);

      checks++;
      if (mon_fault != 0) begin
         errors++;
         $display("FAIL R12 leg exclusion monitor: actual=%0d violations expected=0", mon_fault);
      end
      checks++;
      if (mon_gap != 0) begin
         errors++;
         $display("FAIL R7 off-time monitor: actual=%0d violations expected=0", mon_gap);
      end

      finish_run();
   end
endmodule